// File: doc/BRIEF.md
# Zero-Suppressed Pixel Frame Encoder

The encoder turns one readout chip's slice of a pixel charge map into a zero-suppressed frame. After a start pulse it latches a small frame descriptor: module number, chip number, remap flag, trigger number and readout frame number. It then walks the chip's column window row by row through a synchronous-read map port. Every non-zero charge becomes a hit word. A row-start word comes before the first hit of each row. The result leaves as a byte stream, most significant byte first, under a valid/ready handshake.

The two 32-bit frame headers are held back until the first hit is found. If the window holds no non-zero pixel, the encoder sends a single 32-bit placeholder word instead. It then reports that 8 bytes must be taken off the enclosing byte counters. A frame that carries hits is padded to a 4-byte boundary by repeating its last row-start word. A one-cycle done pulse ends every frame and gives the frame's length in bytes.

Top module: `pixframe_zs_encoder`

## Requirements
- R1: After reset `busy`, `out_valid`, `mem_rd_en` and `frame_done` are all low.
- R2: Bytes 0..3 of a frame with hits hold the outer header: frame type (parameter `ZS_TYPE`) in bits 31:27, module number in 25:20, remap flag in 19, chip number in 17:16, trigger number in 15:0, all other bits zero.
- R3: Chip n reads only columns 64·n to min(64·n+63, NUM_COLS-1). It reads each of them exactly once per frame, rows in ascending order and columns ascending within a row.
- R4: Bytes 4..7 hold the inner header: type (parameter `INNER_TYPE`) in bits 31:29, module number in 23:18, chip number in 17:16, readout frame number in 15:0, bits 28:24 zero.
- R5: Before the first hit of each row a 16-bit row-start word is sent: bit 15 = 0, row bits 9:1 in bits 14:6, bits 5:0 zero.
- R6: Each non-zero pixel sends a 16-bit hit word: bit 15 = 1, row bit 0 in bit 14, column bits 5:0 in bits 13:8, charge in bits 7:0.
- R7: Every 16-bit and 32-bit word goes out most significant byte first. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_byte` stay unchanged.
- R8: When a frame with hits holds an odd number of 16-bit data words, the last row-start word is sent once more, so that every frame length is a multiple of 4.
- R9: A window with no non-zero pixel yields only the 4-byte placeholder word: type `PH_TYPE` in 31:27, module number in 25:20, chip number in 17:16, trigger number in 15:0, other bits zero. `frame_adjust` is then 8; for frames with hits it is 0.
- R10: A chip whose window starts at or beyond NUM_COLS makes no map read and yields the placeholder frame.
- R11: `frame_done` is a one-cycle pulse after the last byte of a frame has been accepted, with `frame_bytes` equal to the bytes sent. A `start` pulse while `busy` is ignored.
- R12: The charge for a read is taken from `mem_charge` in the cycle after `mem_rd_en`, and only one read is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (taken when idle) |
| cfg_module | input | 6 | Module number |
| cfg_chip | input | 2 | Chip number, selects the column window |
| cfg_remap | input | 1 | Remapped-coordinates flag for the outer header |
| cfg_trig | input | 16 | Low trigger number |
| cfg_frame | input | 16 | Readout frame number |
| busy | output | 1 | Frame in progress |
| mem_rd_en | output | 1 | Map read strobe |
| mem_row | output | ROW_W | Map read row |
| mem_col | output | COL_W | Map read column |
| mem_charge | input | 8 | Map read data, one cycle after the strobe |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte accepted |
| out_byte | output | 8 | Output byte |
| frame_done | output | 1 | End-of-frame pulse |
| frame_bytes | output | CNT_W | Length of the finished frame in bytes |
| frame_adjust | output | 4 | Bytes to subtract upstream (8 for a placeholder, else 0) |

## Verification
The bench builds the encoder with NUM_ROWS = 12 and NUM_COLS = 80. Chip 1's window is then clipped to 16 columns, and chips 2 and 3 lie wholly outside the map, so the clipping and the no-read placeholder path are both reached. Twelve rows let the row-start field take several values. Short frames keep run time small, so many random densities, stall patterns and directed padding cases fit in one run.

// File: rtl/pfz_pkg.sv
package pfz_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_READ, ST_CAP, ST_EMIT, ST_FINISH, ST_DONE
  } scan_state_t;

  typedef enum logic [3:0] {
    W_HDR0, W_HDR1, W_HDR2, W_HDR3, W_RS, W_HIT, W_PAD, W_PH0, W_PH1
  } word_sel_t;

  typedef struct packed {
    logic [5:0]  module_id;
    logic [1:0]  chip;
    logic        remap;
    logic [15:0] trig;
    logic [15:0] frame;
  } frame_cfg_t;

  function automatic logic [31:0] fmt_outer(input logic [4:0] ftype, input frame_cfg_t c);
    return {ftype, 1'b0, c.module_id, c.remap, 1'b0, c.chip, c.trig};
  endfunction

  function automatic logic [31:0] fmt_inner(input logic [2:0] itype, input frame_cfg_t c);
    return {itype, 5'b00000, c.module_id, c.chip, c.frame};
  endfunction

  function automatic logic [31:0] fmt_placeholder(input logic [4:0] ptype, input frame_cfg_t c);
    return {ptype, 1'b0, c.module_id, 2'b00, c.chip, c.trig};
  endfunction

  function automatic logic [15:0] fmt_row_start(input logic [9:0] row);
    return {1'b0, row[9:1], 6'b000000};
  endfunction

  function automatic logic [15:0] fmt_hit(input logic [9:0] row, input logic [5:0] col,
                                          input logic [7:0] charge);
    return {1'b1, row[0], col, charge};
  endfunction

endpackage

// File: rtl/pfz_window.sv
module pfz_window #(
  parameter int NUM_COLS = 250,
  parameter int CHIPS    = 4,
  parameter int CHIP_W   = 2,
  parameter int COL_W    = 8
) (
  input  logic [CHIP_W-1:0] chip,
  output logic [COL_W-1:0]  col_lo,
  output logic [COL_W-1:0]  col_hi,
  output logic              empty
);
  localparam int SPAN = 64;

  logic [COL_W-1:0] lo_tab [CHIPS];
  logic [COL_W-1:0] hi_tab [CHIPS];
  logic [CHIPS-1:0] empty_tab;

  for (genvar g = 0; g < CHIPS; g++) begin : g_chip
    localparam int LO   = SPAN * g;
    localparam int HI_R = LO + SPAN - 1;
    localparam int HI   = (HI_R > NUM_COLS - 1) ? NUM_COLS - 1 : HI_R;
    localparam bit EMP  = (LO >= NUM_COLS);
    assign lo_tab[g]    = EMP ? '0 : COL_W'(LO);
    assign hi_tab[g]    = EMP ? '0 : COL_W'(HI);
    assign empty_tab[g] = EMP;
  end

  assign col_lo = lo_tab[chip];
  assign col_hi = hi_tab[chip];
  assign empty  = empty_tab[chip];
endmodule

// File: rtl/pfz_byte_ser.sv
module pfz_byte_ser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        w_valid,
  input  logic [15:0] w_data,
  output logic        w_ready,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_byte,
  output logic        idle
);
  logic [15:0] hold;
  logic [1:0]  left;

  assign out_valid = (left != 2'd0);
  assign out_byte  = (left == 2'd2) ? hold[15:8] : hold[7:0];
  assign w_ready   = (left == 2'd0) || (left == 2'd1 && out_ready);
  assign idle      = (left == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
      left <= 2'd0;
    end else if (w_valid && w_ready) begin
      hold <= w_data;
      left <= 2'd2;
    end else if (out_valid && out_ready) begin
      left <= left - 2'd1;
    end
  end
endmodule

// File: rtl/pfz_scan.sv
module pfz_scan
  import pfz_pkg::*;
#(
  parameter int          NUM_ROWS   = 768,
  parameter int          ROW_W      = 10,
  parameter int          COL_W      = 8,
  parameter int          CNT_W      = 17,
  parameter logic [4:0]  ZS_TYPE    = 5'h05,
  parameter logic [2:0]  INNER_TYPE = 3'h5,
  parameter logic [4:0]  PH_TYPE    = 5'h0B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  frame_cfg_t       cfg,
  output logic [1:0]       cur_chip,
  input  logic [COL_W-1:0] win_lo,
  input  logic [COL_W-1:0] win_hi,
  input  logic             win_empty,
  output logic             busy,
  output logic             mem_rd_en,
  output logic [ROW_W-1:0] mem_row,
  output logic [COL_W-1:0] mem_col,
  input  logic [7:0]       mem_charge,
  output logic             w_valid,
  output logic [15:0]      w_data,
  input  logic             w_ready,
  input  logic             byte_fire,
  input  logic             ser_idle,
  output logic             frame_done,
  output logic [CNT_W-1:0] frame_bytes,
  output logic [3:0]       frame_adjust
);
  scan_state_t      state;
  word_sel_t        sel;
  frame_cfg_t       cfg_q;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [7:0]       pix;
  logic             any_hit, row_open, odd_words;
  logic [15:0]      last_rs;
  logic [CNT_W-1:0] byte_cnt;

  // named internal events
  logic       word_fire, pix_advance, scan_last, row_wrap;
  logic [9:0] row10;
  logic [5:0] col6;
  logic [31:0] outer_w, inner_w, ph_w;

  assign row10       = 10'(row);
  assign col6        = 6'(col);
  assign outer_w     = fmt_outer(ZS_TYPE, cfg_q);
  assign inner_w     = fmt_inner(INNER_TYPE, cfg_q);
  assign ph_w        = fmt_placeholder(PH_TYPE, cfg_q);
  assign word_fire   = (state == ST_EMIT) && w_ready;
  assign pix_advance = ((state == ST_CAP) && (mem_charge == 8'd0)) ||
                       (word_fire && sel == W_HIT);
  assign row_wrap    = (col == win_hi);
  assign scan_last   = row_wrap && (row == ROW_W'(NUM_ROWS - 1));

  assign cur_chip  = cfg_q.chip;
  assign busy      = (state != ST_IDLE);
  assign mem_rd_en = (state == ST_READ);
  assign mem_row   = row;
  assign mem_col   = col;
  assign w_valid   = (state == ST_EMIT);

  always_comb begin
    unique case (sel)
      W_HDR0:  w_data = outer_w[31:16];
      W_HDR1:  w_data = outer_w[15:0];
      W_HDR2:  w_data = inner_w[31:16];
      W_HDR3:  w_data = inner_w[15:0];
      W_RS:    w_data = fmt_row_start(row10);
      W_HIT:   w_data = fmt_hit(row10, col6, pix);
      W_PAD:   w_data = last_rs;
      W_PH0:   w_data = ph_w[31:16];
      W_PH1:   w_data = ph_w[15:0];
      default: w_data = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      sel          <= W_HDR0;
      cfg_q        <= '0;
      row          <= '0;
      col          <= '0;
      pix          <= '0;
      any_hit      <= 1'b0;
      row_open     <= 1'b0;
      odd_words    <= 1'b0;
      last_rs      <= '0;
      byte_cnt     <= '0;
      frame_done   <= 1'b0;
      frame_bytes  <= '0;
      frame_adjust <= '0;
    end else begin
      frame_done <= 1'b0;
      if (byte_fire) byte_cnt <= byte_cnt + CNT_W'(1);

      if (pix_advance) begin
        if (row_wrap) begin
          col      <= win_lo;
          row      <= row + 1'b1;
          row_open <= 1'b0;
        end else begin
          col <= col + 1'b1;
        end
      end

      unique case (state)
        ST_IDLE: if (start) begin
          cfg_q     <= cfg;
          any_hit   <= 1'b0;
          row_open  <= 1'b0;
          odd_words <= 1'b0;
          byte_cnt  <= '0;
          state     <= ST_LOAD;
        end
        ST_LOAD: begin
          row   <= '0;
          col   <= win_lo;
          state <= win_empty ? ST_FINISH : ST_READ;
        end
        ST_READ: state <= ST_CAP;
        ST_CAP: begin
          pix <= mem_charge;
          if (mem_charge != 8'd0) begin
            state <= ST_EMIT;
            if (!any_hit)       sel <= W_HDR0;
            else if (!row_open) sel <= W_RS;
            else                sel <= W_HIT;
          end else begin
            state <= scan_last ? ST_FINISH : ST_READ;
          end
        end
        ST_EMIT: if (w_ready) begin
          unique case (sel)
            W_HDR0: sel <= W_HDR1;
            W_HDR1: sel <= W_HDR2;
            W_HDR2: sel <= W_HDR3;
            W_HDR3: begin sel <= W_RS; any_hit <= 1'b1; end
            W_RS: begin
              sel       <= W_HIT;
              row_open  <= 1'b1;
              last_rs   <= w_data;
              odd_words <= ~odd_words;
            end
            W_HIT: begin
              odd_words <= ~odd_words;
              state     <= scan_last ? ST_FINISH : ST_READ;
            end
            W_PH0:   sel <= W_PH1;
            default: state <= ST_DONE;
          endcase
        end
        ST_FINISH: begin
          if (!any_hit) begin
            sel <= W_PH0; state <= ST_EMIT;
          end else if (odd_words) begin
            sel <= W_PAD; state <= ST_EMIT;
          end else begin
            state <= ST_DONE;
          end
        end
        ST_DONE: if (ser_idle) begin
          frame_done   <= 1'b1;
          frame_bytes  <= byte_cnt;
          frame_adjust <= any_hit ? 4'd0 : 4'd8;
          state        <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pixframe_zs_encoder.sv
module pixframe_zs_encoder
  import pfz_pkg::*;
#(
  parameter int         NUM_ROWS   = 768,
  parameter int         NUM_COLS   = 250,
  parameter logic [4:0] ZS_TYPE    = 5'h05,
  parameter logic [2:0] INNER_TYPE = 3'h5,
  parameter logic [4:0] PH_TYPE    = 5'h0B,
  localparam int ROW_W     = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int COL_W     = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int MAX_BYTES = 8 + 2 * NUM_ROWS * 65 + 2,
  localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [5:0]       cfg_module,
  input  logic [1:0]       cfg_chip,
  input  logic             cfg_remap,
  input  logic [15:0]      cfg_trig,
  input  logic [15:0]      cfg_frame,
  output logic             busy,
  output logic             mem_rd_en,
  output logic [ROW_W-1:0] mem_row,
  output logic [COL_W-1:0] mem_col,
  input  logic [7:0]       mem_charge,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_byte,
  output logic             frame_done,
  output logic [CNT_W-1:0] frame_bytes,
  output logic [3:0]       frame_adjust
);
  frame_cfg_t       cfg_in;
  logic [1:0]       cur_chip;
  logic [COL_W-1:0] win_lo, win_hi;
  logic             win_empty;
  logic             w_valid, w_ready, ser_idle, byte_fire;
  logic [15:0]      w_data;

  assign cfg_in    = '{module_id: cfg_module, chip: cfg_chip, remap: cfg_remap,
                       trig: cfg_trig, frame: cfg_frame};
  assign byte_fire = out_valid && out_ready;

  pfz_window #(.NUM_COLS(NUM_COLS), .CHIPS(4), .CHIP_W(2), .COL_W(COL_W)) u_window (
    .chip(cur_chip), .col_lo(win_lo), .col_hi(win_hi), .empty(win_empty)
  );

  pfz_scan #(
    .NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W),
    .ZS_TYPE(ZS_TYPE), .INNER_TYPE(INNER_TYPE), .PH_TYPE(PH_TYPE)
  ) u_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg_in), .cur_chip(cur_chip),
    .win_lo(win_lo), .win_hi(win_hi), .win_empty(win_empty), .busy(busy),
    .mem_rd_en(mem_rd_en), .mem_row(mem_row), .mem_col(mem_col), .mem_charge(mem_charge),
    .w_valid(w_valid), .w_data(w_data), .w_ready(w_ready), .byte_fire(byte_fire),
    .ser_idle(ser_idle), .frame_done(frame_done), .frame_bytes(frame_bytes),
    .frame_adjust(frame_adjust)
  );

  pfz_byte_ser u_ser (
    .clk(clk), .rst_n(rst_n), .w_valid(w_valid), .w_data(w_data), .w_ready(w_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte), .idle(ser_idle)
  );
endmodule

// File: rtl/pfz_checker.sv
module pfz_checker #(
  parameter int NUM_COLS = 250,
  parameter int COL_W    = 8,
  parameter int CNT_W    = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mem_rd_en,
  input logic [COL_W-1:0] mem_col,
  input logic [1:0]       cur_chip,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_byte,
  input logic             frame_done,
  input logic [CNT_W-1:0] frame_bytes,
  input logic [3:0]       frame_adjust
);
  p_rd_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> ((int'(mem_col) / 64) == int'(cur_chip)) && (int'(mem_col) < NUM_COLS));

  p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  p_len_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (frame_bytes[1:0] == 2'b00) && (frame_bytes >= CNT_W'(4)));

  p_placeholder_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_adjust != 4'd0) |-> (frame_adjust == 4'd8) && (frame_bytes == CNT_W'(4)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !busy && !out_valid);

  p_one_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
endmodule

bind pixframe_zs_encoder pfz_checker #(.NUM_COLS(NUM_COLS), .COL_W(COL_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_rd_en(mem_rd_en), .mem_col(mem_col),
  .cur_chip(cur_chip), .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
  .frame_done(frame_done), .frame_bytes(frame_bytes), .frame_adjust(frame_adjust)
);

// File: tb/pixframe_zs_encoder_test.sv
module pixframe_zs_encoder_test;
  localparam int         ROWS  = 12;
  localparam int         COLS  = 80;
  localparam logic [4:0] ZT    = 5'h05;
  localparam logic [2:0] IT    = 3'h5;
  localparam logic [4:0] PT    = 5'h0B;
  localparam int         ROW_W = $clog2(ROWS);
  localparam int         COL_W = $clog2(COLS);
  localparam int         CNT_W = $clog2(8 + 2 * ROWS * 65 + 2 + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [5:0] cfg_module = '0;
  logic [1:0] cfg_chip = '0;
  logic cfg_remap = 1'b0;
  logic [15:0] cfg_trig = '0, cfg_frame = '0;
  logic busy, mem_rd_en, out_valid, frame_done;
  logic out_ready = 1'b0;
  logic [ROW_W-1:0] mem_row;
  logic [COL_W-1:0] mem_col;
  logic [7:0] mem_charge = '0, out_byte;
  logic [CNT_W-1:0] frame_bytes;
  logic [3:0] frame_adjust;

  always #4 clk = ~clk;

  pixframe_zs_encoder #(.NUM_ROWS(ROWS), .NUM_COLS(COLS), .ZS_TYPE(ZT),
                        .INNER_TYPE(IT), .PH_TYPE(PT)) uut (.*);

  logic [7:0] pmap [ROWS][COLS];
  always @(posedge clk) if (mem_rd_en) mem_charge <= pmap[mem_row][mem_col];

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$], got_q[$];
  int exp_adj;
  int mon_lo, mon_hi, nread = 0, bad_reads = 0, stall_err = 0;
  bit rnd_ready = 0, done_seen = 0, prev_stall = 0;
  logic [7:0] prev_byte;
  int got_len, got_adj;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: drive ready, collect bytes, watch reads
  always @(negedge clk) begin
    if (rst_n) begin
      out_ready = rnd_ready ? (($urandom % 4) != 0) : 1'b1;
      if (prev_stall && (!out_valid || out_byte != prev_byte)) stall_err++;
      prev_stall = out_valid && !out_ready;
      prev_byte  = out_byte;
      if (out_valid && out_ready) got_q.push_back(out_byte);
      if (mem_rd_en) begin
        nread++;
        if (int'(mem_col) < mon_lo || int'(mem_col) > mon_hi) bad_reads++;
      end
      if (frame_done) begin
        done_seen = 1;
        got_len = int'(frame_bytes);
        got_adj = int'(frame_adjust);
      end
    end
  end

  function automatic void push32(input logic [31:0] w);
    for (int k = 3; k >= 0; k--) exp_q.push_back(w[8*k +: 8]);
  endfunction

  function automatic void build_exp(input int m, input int ch, input int rm,
                                    input int tr, input int fn);
    logic [15:0] words[$];
    logic [15:0] lastrs;
    int lo, hi;
    exp_q.delete();
    lo = 64 * ch;
    hi = (lo + 63 < COLS) ? lo + 63 : COLS - 1;
    lastrs = 0;
    if (lo < COLS)
      for (int r = 0; r < ROWS; r++) begin
        bit opened = 0;
        for (int c = lo; c <= hi; c++)
          if (pmap[r][c] != 0) begin
            if (!opened) begin
              lastrs = 16'((r / 2) * 64);
              words.push_back(lastrs);
              opened = 1;
            end
            words.push_back(16'(32768 + (r % 2) * 16384 + (c % 64) * 256 + int'(pmap[r][c])));
          end
      end
    if (words.size() == 0) begin
      push32(32'(int'(PT) * (1 << 27) + m * (1 << 20) + ch * (1 << 16) + tr));
      exp_adj = 8;
    end else begin
      push32(32'(int'(ZT) * (1 << 27) + m * (1 << 20) + rm * (1 << 19) + ch * (1 << 16) + tr));
      push32(32'(int'(IT) * (1 << 29) + m * (1 << 18) + ch * (1 << 16) + fn));
      if (words.size() % 2 == 1) words.push_back(lastrs);
      foreach (words[i]) begin
        exp_q.push_back(words[i][15:8]);
        exp_q.push_back(words[i][7:0]);
      end
      exp_adj = 0;
    end
  endfunction

  task automatic fill(input int density);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        pmap[r][c] = (($urandom % 100) < density) ? 8'(($urandom % 255) + 1) : 8'd0;
  endtask

  task automatic clear_map();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) pmap[r][c] = 8'd0;
  endtask

  task automatic run_frame(input int m, input int ch, input int rm, input int tr,
                           input int fn, input string tag, input bit poke);
    int lo, hi, exp_reads, t, bad;
    build_exp(m, ch, rm, tr, fn);
    lo = 64 * ch;
    hi = (lo + 63 < COLS) ? lo + 63 : COLS - 1;
    exp_reads = (lo < COLS) ? ROWS * (hi - lo + 1) : 0;
    mon_lo = lo; mon_hi = hi;
    @(negedge clk);
    got_q.delete(); nread = 0; done_seen = 0;
    cfg_module = 6'(m); cfg_chip = 2'(ch); cfg_remap = 1'(rm);
    cfg_trig = 16'(tr); cfg_frame = 16'(fn);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      cfg_module = ~cfg_module; cfg_chip = cfg_chip + 2'd1; cfg_trig = ~cfg_trig;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done_seen && t < 40000) begin
      @(negedge clk);
      t++;
    end
    repeat (2) @(negedge clk);
    chk(done_seen, "R11", {tag, " frame_done seen"}, done_seen, 1);
    chk(got_len == exp_q.size() && got_q.size() == exp_q.size(), "R11",
        {tag, " frame_bytes"}, got_len, exp_q.size());
    bad = -1;
    foreach (exp_q[i]) if (bad < 0 && (i >= got_q.size() || got_q[i] != exp_q[i])) bad = i;
    if (bad >= 0)
      chk(0, "R2 R4 R5 R6 R7 R8 R12", {tag, " byte content at index below"},
          (bad < got_q.size()) ? got_q[bad] : -1, exp_q[bad]);
    else
      chk(1, "R2 R4 R5 R6 R7 R8 R12", {tag, " byte content"}, 0, 0);
    chk(got_adj == exp_adj, "R9", {tag, " frame_adjust"}, got_adj, exp_adj);
    chk(nread == exp_reads, "R3 R10", {tag, " read count"}, nread, exp_reads);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C0D));
    clear_map();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy, "R1", "busy after reset", busy, 0);
    chk(!out_valid, "R1", "out_valid after reset", out_valid, 0);
    chk(!mem_rd_en, "R1", "mem_rd_en after reset", mem_rd_en, 0);
    chk(!frame_done, "R1", "frame_done after reset", frame_done, 0);

    // R9: empty window, placeholder frame
    run_frame(5, 0, 1, 16'h1234, 16'hABCD, "r9_empty", 0);
    // R10: chip window wholly beyond the map
    fill(50);
    run_frame(7, 2, 0, 16'h00FF, 16'h0001, "r10_outside", 0);
    run_frame(9, 3, 1, 16'h8001, 16'h0002, "r10_outside3", 0);
    // R5 R6: single hit, no padding
    clear_map(); pmap[0][0] = 8'h11;
    run_frame(1, 0, 0, 16'h0042, 16'h7777, "r6_single", 0);
    // R8: two hits in one row make an odd word count
    clear_map(); pmap[5][3] = 8'h80; pmap[5][60] = 8'hFF;
    run_frame(63, 0, 1, 16'hFFFF, 16'hFFFF, "r8_pad", 0);
    // R3: last pixel of clipped chip 1 window
    clear_map(); pmap[ROWS-1][COLS-1] = 8'hFF; pmap[ROWS-1][63] = 8'h01;
    run_frame(33, 1, 0, 16'h5A5A, 16'hA5A5, "r3_clip", 0);
    // R7: dense map with random backpressure
    rnd_ready = 1;
    fill(100);
    run_frame(17, 1, 1, 16'h0F0F, 16'h3C3C, "r7_dense", 0);
    // R11: start while busy ignored
    fill(10);
    run_frame(12, 0, 1, 16'h2222, 16'h4444, "r11_poke", 1);

    for (int f = 0; f < 16; f++) begin
      int dens;
      case ($urandom % 4)
        0: dens = 0;
        1: dens = 2;
        2: dens = 15;
        default: dens = 40;
      endcase
      rnd_ready = ($urandom % 2) == 1;
      fill(dens);
      run_frame(int'($urandom % 64), int'($urandom % 4), int'($urandom % 2),
                int'($urandom % 65536), int'($urandom % 65536), "random", 0);
    end

    chk(stall_err == 0, "R7", "byte held while stalled", stall_err, 0);
    chk(bad_reads == 0, "R3", "reads outside window", bad_reads, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule